// File: doc/BRIEF.md
# Serial Flash Command Sequencer

This block is the master side of a four-wire serial flash link. It has one chip select, one serial clock, one data line out and one data line in. A client asks for one whole operation on a small request port: read, page program, sector erase, bulk erase, status write or identifier read. The request carries a command code, a 24-bit byte address and a byte count. The sequencer then builds every frame the operation needs on the serial pins, with no further help from the client.

For commands that change the flash, the block first sends its own write-enable frame. It then sends the main frame: opcode, address and data. After that it reads the status register in separate short frames until the busy bit clears. Bytes to be written are pulled from the client one at a time through a byte-taken strobe. Bytes that are read come back with a one-cycle valid strobe. The end of each request is reported by a single done pulse, with an error flag for a poll that ran out of budget.

The serial clock is the system clock divided by `2*CLK_DIV`, in SPI mode 0. Chip select goes high between any two frames.

Top module: `spi_flash_seq`

## Requirements
- R1: After reset, cs_no is 1, sclk_o is 0, busy_o is 0 and done_o is 0.
- R2: Serial timing is SPI mode 0.
  - sclk_o idles low whenever cs_no is high.
  - Each high phase and each low phase inside a byte lasts CLK_DIV system cycles.
  - mosi_o changes only while sclk_o is low.
  - Bytes go out most significant bit first.
- R3: Command codes on req_cmd_i are: 0 read, 1 page program, 2 sector erase, 3 bulk erase, 4 write status, 5 read identifier.
  - Program (opcode 0x02), sector erase (0xD8), bulk erase (0xC7) and write status (0x01) are each preceded by a separate frame holding only 0x06.
  - Read (0x03) and identifier read (0xAB) are not preceded by that frame.
- R4: For read, program and sector erase, the opcode is followed by the 24-bit address, most significant byte first.
  - A read returns req_len_i bytes from consecutive addresses in one frame.
  - Each returned byte appears on rdata_o with a one-cycle rdata_valid_o.
- R5: Page program sends req_len_i data bytes (1 to 256) from wdata_i.
  - wdata_ack_o pulses once per byte taken, and the client then presents the next byte.
  - Bytes land at addresses that wrap inside the 256-byte page.
  - Other bytes of the page are left unchanged.
- R6: After every modifying frame, the block reads the status register in separate frames (0x05 followed by one read byte).
  - It stops when bit 0 of the status byte is 0.
  - done_o comes only after that, with err_o low.
- R7: If bit 0 of the status byte is still 1 after POLL_LIMIT status frames, the request ends with done_o and err_o both high, and no further status frames are sent.
- R8: Identifier read sends 0xAB and three 0x00 bytes, then returns one byte on rdata_o.
- R9: Between two frames, cs_no stays high for at least 2*CLK_DIV system cycles.
- R10: A request is taken only while busy_o is low.
  - busy_o stays high until the request's single-cycle done_o.
  - req_valid_i while busy has no effect: no extra frame and no extra done_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe, taken when idle |
| req_cmd_i | input | 3 | Command code |
| req_addr_i | input | 24 | Byte address |
| req_len_i | input | LEN_W | Data byte count for read and program |
| wdata_i | input | 8 | Next byte to write |
| wdata_ack_o | output | 1 | Current write byte taken |
| rdata_o | output | 8 | Byte read from flash |
| rdata_valid_o | output | 1 | rdata_o is valid this cycle |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | Request finished (one cycle) |
| err_o | output | 1 | Status poll budget exhausted, valid with done_o |
| cs_no | output | 1 | Flash chip select, active low |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to flash |
| miso_i | input | 1 | Serial data from flash |

## Verification
The hardest case to reach is the poll-budget expiry. The flash must keep reporting busy for longer than the sequencer is willing to wait. A well-behaved device never gets there from a normal request.

The bench's behavioural flash therefore has a settable count of busy status reads that follows each modifying frame. Setting that count above POLL_LIMIT forces the error exit. Setting it to zero and to a small value checks the exact number of status frames against the count.

Page wrap-around is reached by programming from near the end of a page. The result is checked against a memory image computed in the bench.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    CMD_READ   = 3'd0,
    CMD_PROG   = 3'd1,
    CMD_SERASE = 3'd2,
    CMD_BERASE = 3'd3,
    CMD_WRSR   = 3'd4,
    CMD_RDID   = 3'd5
  } cmd_e;

  typedef enum logic [1:0] {
    FR_WREN = 2'd0,
    FR_MAIN = 2'd1,
    FR_POLL = 2'd2
  } frame_e;

  localparam logic [7:0] OP_WREN   = 8'h06;
  localparam logic [7:0] OP_RDSR   = 8'h05;
  localparam logic [7:0] OP_WRSR   = 8'h01;
  localparam logic [7:0] OP_READ   = 8'h03;
  localparam logic [7:0] OP_PROG   = 8'h02;
  localparam logic [7:0] OP_SERASE = 8'hD8;
  localparam logic [7:0] OP_BERASE = 8'hC7;
  localparam logic [7:0] OP_RDID   = 8'hAB;

  function automatic logic [7:0] cmd_opcode(cmd_e c);
    case (c)
      CMD_READ:   return OP_READ;
      CMD_PROG:   return OP_PROG;
      CMD_SERASE: return OP_SERASE;
      CMD_BERASE: return OP_BERASE;
      CMD_WRSR:   return OP_WRSR;
      default:    return OP_RDID;
    endcase
  endfunction

  function automatic logic cmd_modifies(cmd_e c);
    return (c == CMD_PROG) || (c == CMD_SERASE) ||
           (c == CMD_BERASE) || (c == CMD_WRSR);
  endfunction

endpackage

// File: rtl/spi_byte_shift.sv
module spi_byte_shift #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] tx_i,
  input  logic       miso_i,
  output logic       sclk_o,
  output logic       mosi_o,
  output logic       done_o,
  output logic [7:0] rx_o
);

  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic             busy_q, sclk_q, mosi_q, done_q;
  logic [7:0]       tx_q, rx_q;
  logic [2:0]       bit_q;
  logic [DIV_W-1:0] div_q;
  logic             tick;

  assign tick = busy_q && (div_q == DIV_W'(CLK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      mosi_q <= 1'b0;
      done_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      div_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        mosi_q <= tx_i[7];
        tx_q   <= {tx_i[6:0], 1'b0};
        bit_q  <= '0;
        div_q  <= '0;
      end else if (busy_q) begin
        if (tick) begin
          div_q <= '0;
          if (!sclk_q) begin
            // rising edge: sample
            sclk_q <= 1'b1;
            rx_q   <= {rx_q[6:0], miso_i};
          end else begin
            // falling edge: launch next bit
            sclk_q <= 1'b0;
            if (bit_q == 3'd7) begin
              busy_q <= 1'b0;
              done_q <= 1'b1;
            end else begin
              bit_q  <= bit_q + 3'd1;
              mosi_q <= tx_q[7];
              tx_q   <= {tx_q[6:0], 1'b0};
            end
          end
        end else begin
          div_q <= div_q + DIV_W'(1);
        end
      end
    end
  end

  assign sclk_o = sclk_q;
  assign mosi_o = mosi_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;

  a_r2_mosi_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_q |-> $stable(mosi_q));

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_seq_pkg::*;
#(
  parameter int LEN_W      = 9,
  parameter int POLL_LIMIT = 4096,
  parameter int GAP        = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_cmd_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wdata_i,
  output logic             wdata_ack_o,
  output logic [7:0]       rdata_o,
  output logic             rdata_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cs_no,
  output logic             xfer_start_o,
  output logic [7:0]       xfer_tx_o,
  input  logic             xfer_done_i,
  input  logic [7:0]       xfer_rx_i
);

  localparam int IDX_W = LEN_W + 1;
  localparam int PW    = $clog2(POLL_LIMIT + 1);
  localparam int GW    = $clog2(GAP + 1);

  typedef enum logic [1:0] {S_IDLE, S_GAP, S_LOAD, S_WAIT} st_e;

  st_e              st_q;
  frame_e           frame_q;
  cmd_e             cmd_q;
  logic [23:0]      addr_q;
  logic [LEN_W-1:0] len_q;
  logic [IDX_W-1:0] idx_q;
  logic [GW-1:0]    gap_q;
  logic [PW-1:0]    poll_q;
  logic             done_q, err_q, ack_q, rv_q;
  logic [7:0]       rdata_q;

  logic [7:0]       tx_byte, addr_byte;
  logic             is_wr, is_rd;
  logic [IDX_W-1:0] last;

  always_comb begin
    case (idx_q[1:0])
      2'd1:    addr_byte = addr_q[23:16];
      2'd2:    addr_byte = addr_q[15:8];
      default: addr_byte = addr_q[7:0];
    endcase
  end

  always_comb begin
    tx_byte = 8'h00;
    is_wr   = 1'b0;
    is_rd   = 1'b0;
    last    = '0;
    case (frame_q)
      FR_WREN: tx_byte = OP_WREN;
      FR_POLL: begin
        last    = IDX_W'(1);
        tx_byte = (idx_q == '0) ? OP_RDSR : 8'h00;
      end
      default: begin
        case (cmd_q)
          CMD_READ, CMD_PROG: last = IDX_W'(len_q) + IDX_W'(3);
          CMD_SERASE:         last = IDX_W'(3);
          CMD_WRSR:           last = IDX_W'(1);
          CMD_RDID:           last = IDX_W'(4);
          default:            last = '0;
        endcase
        if (idx_q == '0) begin
          tx_byte = cmd_opcode(cmd_q);
        end else begin
          case (cmd_q)
            CMD_READ: begin
              if (idx_q <= IDX_W'(3)) tx_byte = addr_byte;
              else                    is_rd   = 1'b1;
            end
            CMD_PROG: begin
              if (idx_q <= IDX_W'(3)) tx_byte = addr_byte;
              else begin
                is_wr   = 1'b1;
                tx_byte = wdata_i;
              end
            end
            CMD_SERASE: tx_byte = addr_byte;
            CMD_WRSR: begin
              is_wr   = 1'b1;
              tx_byte = wdata_i;
            end
            CMD_RDID: is_rd = (idx_q == IDX_W'(4));
            default:  tx_byte = 8'h00;
          endcase
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      frame_q <= FR_MAIN;
      cmd_q   <= CMD_READ;
      addr_q  <= '0;
      len_q   <= '0;
      idx_q   <= '0;
      gap_q   <= '0;
      poll_q  <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      ack_q   <= 1'b0;
      rv_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      ack_q  <= 1'b0;
      rv_q   <= 1'b0;
      case (st_q)
        S_IDLE: begin
          if (req_valid_i) begin
            cmd_q   <= cmd_e'(req_cmd_i);
            addr_q  <= req_addr_i;
            len_q   <= req_len_i;
            frame_q <= cmd_modifies(cmd_e'(req_cmd_i)) ? FR_WREN : FR_MAIN;
            idx_q   <= '0;
            gap_q   <= '0;
            poll_q  <= '0;
            st_q    <= S_GAP;
          end
        end
        S_GAP: begin
          if (gap_q == GW'(GAP - 1)) begin
            gap_q <= '0;
            st_q  <= S_LOAD;
          end else begin
            gap_q <= gap_q + GW'(1);
          end
        end
        S_LOAD: begin
          ack_q <= is_wr;
          st_q  <= S_WAIT;
        end
        default: begin
          if (xfer_done_i) begin
            if (is_rd) begin
              rdata_q <= xfer_rx_i;
              rv_q    <= 1'b1;
            end
            if (idx_q == last) begin
              idx_q <= '0;
              st_q  <= S_GAP;
              case (frame_q)
                FR_WREN: frame_q <= FR_MAIN;
                FR_MAIN: begin
                  if (cmd_modifies(cmd_q)) frame_q <= FR_POLL;
                  else begin
                    st_q   <= S_IDLE;
                    done_q <= 1'b1;
                  end
                end
                default: begin
                  if (!xfer_rx_i[0]) begin
                    st_q   <= S_IDLE;
                    done_q <= 1'b1;
                  end else if (poll_q == PW'(POLL_LIMIT - 1)) begin
                    st_q   <= S_IDLE;
                    done_q <= 1'b1;
                    err_q  <= 1'b1;
                  end else begin
                    poll_q <= poll_q + PW'(1);
                  end
                end
              endcase
            end else begin
              idx_q <= idx_q + IDX_W'(1);
              st_q  <= S_LOAD;
            end
          end
        end
      endcase
    end
  end

  assign cs_no         = !((st_q == S_LOAD) || (st_q == S_WAIT));
  assign busy_o        = (st_q != S_IDLE);
  assign xfer_start_o  = (st_q == S_LOAD);
  assign xfer_tx_o     = tx_byte;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign wdata_ack_o   = ack_q;
  assign rdata_o       = rdata_q;
  assign rdata_valid_o = rv_q;

  a_r9_cs_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_no) |=> cs_no);

  a_r10_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r7_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);

  a_r6_poll_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == S_WAIT) |-> (poll_q < PW'(POLL_LIMIT)));

  a_r5_ack_main_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdata_ack_o |-> (frame_q == FR_MAIN));

endmodule

// File: rtl/spi_flash_seq.sv
module spi_flash_seq #(
  parameter int CLK_DIV    = 2,
  parameter int LEN_W      = 9,
  parameter int POLL_LIMIT = 4096
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [2:0]       req_cmd_i,
  input  logic [23:0]      req_addr_i,
  input  logic [LEN_W-1:0] req_len_i,
  input  logic [7:0]       wdata_i,
  output logic             wdata_ack_o,
  output logic [7:0]       rdata_o,
  output logic             rdata_valid_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);

  localparam int GAP = 2 * CLK_DIV;

  logic       xfer_start, xfer_done;
  logic [7:0] xfer_tx, xfer_rx;

  spi_seq_fsm #(
    .LEN_W      (LEN_W),
    .POLL_LIMIT (POLL_LIMIT),
    .GAP        (GAP)
  ) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .req_valid_i   (req_valid_i),
    .req_cmd_i     (req_cmd_i),
    .req_addr_i    (req_addr_i),
    .req_len_i     (req_len_i),
    .wdata_i       (wdata_i),
    .wdata_ack_o   (wdata_ack_o),
    .rdata_o       (rdata_o),
    .rdata_valid_o (rdata_valid_o),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .err_o         (err_o),
    .cs_no         (cs_no),
    .xfer_start_o  (xfer_start),
    .xfer_tx_o     (xfer_tx),
    .xfer_done_i   (xfer_done),
    .xfer_rx_i     (xfer_rx)
  );

  spi_byte_shift #(
    .CLK_DIV (CLK_DIV)
  ) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (xfer_start),
    .tx_i    (xfer_tx),
    .miso_i  (miso_i),
    .sclk_o  (sclk_o),
    .mosi_o  (mosi_o),
    .done_o  (xfer_done),
    .rx_o    (xfer_rx)
  );

  a_r2_sclk_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !sclk_o);

endmodule

// File: tb/sim_spi_flash_seq.sv
module sim_spi_flash_seq;

  localparam int CLK_DIV    = 2;
  localparam int LEN_W      = 9;
  localparam int POLL_LIMIT = 6;
  localparam logic [7:0] ID_BYTE = 8'h5A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic             req_valid = 1'b0;
  logic [2:0]       req_cmd = '0;
  logic [23:0]      req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [7:0]       wdata;
  logic             wdata_ack, rdata_valid, busy, done, err;
  logic [7:0]       rdata;
  logic             cs_n, sclk, mosi;
  logic             miso = 1'b0;

  logic [7:0] wbuf [0:511];
  logic [8:0] widx = '0;
  assign wdata = wbuf[widx];

  spi_flash_seq #(.CLK_DIV(CLK_DIV), .LEN_W(LEN_W), .POLL_LIMIT(POLL_LIMIT)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_cmd_i(req_cmd),
    .req_addr_i(req_addr), .req_len_i(req_len), .wdata_i(wdata),
    .wdata_ack_o(wdata_ack), .rdata_o(rdata), .rdata_valid_o(rdata_valid),
    .busy_o(busy), .done_o(done), .err_o(err), .cs_no(cs_n), .sclk_o(sclk),
    .mosi_o(mosi), .miso_i(miso)
  );

  int tests = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- behavioural flash ----------------
  logic [7:0]  mem [0:1023];
  logic [7:0]  exp_mem [0:1023];
  logic [7:0]  sh_in = '0, out_sr = '0, op = '0, sr_val = '0;
  logic [7:0]  fbytes [0:7];
  logic [7:0]  hdr [0:3];
  logic [23:0] m_addr = '0;
  logic        wel = 1'b0;
  int bitc = 0, bytec = 0, wip_left = 0, busy_n = 0;
  int violations = 0, wren_frames = 0, rdsr_frames = 0, frames = 0;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      mem[i] = 8'hFF;
      exp_mem[i] = 8'hFF;
    end
    for (int i = 0; i < 8; i++) fbytes[i] = 8'h00;
    for (int i = 0; i < 4; i++) hdr[i] = 8'h00;
  end

  task automatic model_byte(input logic [7:0] b);
    logic [7:0] lo;
    if (bytec < 8) fbytes[bytec] = b;
    if (bytec == 0) op = b;
    if (bytec >= 1 && bytec <= 3 && (op == 8'h03 || op == 8'h02 || op == 8'hD8))
      m_addr = {m_addr[15:0], b};
    case (op)
      8'h05: out_sr = {6'b0, wel, (wip_left > 0)};
      8'h03: if (bytec >= 3) begin
        out_sr = mem[m_addr[9:0]];
        m_addr = m_addr + 24'd1;
      end
      8'h02: if (bytec >= 4) begin
        lo = m_addr[7:0] + 8'(bytec - 4);
        mem[{m_addr[9:8], lo}] = mem[{m_addr[9:8], lo}] & b;
      end
      8'h01: if (bytec == 1) sr_val = b;
      8'hAB: if (bytec == 3) out_sr = ID_BYTE;
      default: out_sr = 8'h00;
    endcase
  endtask

  always @(negedge cs_n) begin
    bitc = 0;
    bytec = 0;
    out_sr = 8'h00;
    frames++;
  end

  always @(posedge sclk) if (cs_n === 1'b0) begin
    sh_in = {sh_in[6:0], mosi};
    bitc++;
    if (bitc % 8 == 0) begin
      model_byte(sh_in);
      bytec++;
    end
  end

  always @(negedge sclk) if (cs_n === 1'b0) begin
    miso = out_sr[7];
    out_sr = {out_sr[6:0], 1'b0};
  end

  always @(posedge cs_n) if (bytec > 0) begin
    if (op != 8'h05 && wip_left > 0) violations++;
    case (op)
      8'h06: begin wel = 1'b1; wren_frames++; end
      8'h05: begin rdsr_frames++; if (wip_left > 0) wip_left--; end
      8'h02, 8'hD8, 8'hC7, 8'h01: begin
        if (!wel) violations++;
        if (op == 8'hD8)
          for (int i = 0; i < 512; i++) mem[{m_addr[9], 9'(i)}] = 8'hFF;
        if (op == 8'hC7)
          for (int i = 0; i < 1024; i++) mem[i] = 8'hFF;
        wel = 1'b0;
        wip_left = busy_n;
      end
      default: ;
    endcase
    if (op != 8'h05 && op != 8'h06)
      for (int i = 0; i < 4; i++) hdr[i] = fbytes[i];
  end

  // ---------------- observers ----------------
  logic [7:0] rbuf [0:511];
  int rcnt = 0, done_cnt = 0;
  int hi_run = 0, min_gap = 1000000, sc_hi = 0, sc_lo = 0;
  int min_hi = 1000000, max_hi = 0, min_lo = 1000000;
  bit seen_frame = 1'b0;

  always @(negedge clk) if (rst_ni) begin
    if (rdata_valid) begin
      rbuf[rcnt[8:0]] = rdata;
      rcnt++;
    end
    if (done) done_cnt++;
    if (wdata_ack) widx = widx + 9'd1;
    if (cs_n) hi_run++;
    else begin
      if (seen_frame && hi_run > 0 && hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
      seen_frame = 1'b1;
    end
    if (sclk) begin
      sc_hi++;
      if (sc_lo > 0 && sc_lo < min_lo) min_lo = sc_lo;
      sc_lo = 0;
    end else begin
      if (sc_hi > 0) begin
        if (sc_hi < min_hi) min_hi = sc_hi;
        if (sc_hi > max_hi) max_hi = sc_hi;
      end
      sc_hi = 0;
      if (!cs_n) sc_lo++;
      else sc_lo = 0;
    end
  end

  // ---------------- stimulus ----------------
  task automatic do_req(input logic [2:0] c, input int a, input int n, output bit e);
    @(negedge clk);
    rcnt = 0;
    widx = '0;
    req_valid = 1'b1;
    req_cmd = c;
    req_addr = 24'(a);
    req_len = LEN_W'(n);
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    e = err;
    @(negedge clk);
  endtask

  task automatic rd_check(input int a, input int n, input string tag);
    bit e;
    int bad = 0, act = 0, expv = 0;
    do_req(3'd0, a, n, e);
    chk(rcnt == n && !e, tag, rcnt, n);
    for (int i = 0; i < n; i++)
      if (rbuf[i] !== exp_mem[(a + i) % 1024]) begin
        if (bad == 0) begin act = int'(rbuf[i]); expv = int'(exp_mem[(a + i) % 1024]); end
        bad++;
      end
    chk(bad == 0, tag, act, expv);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    bit e;
    int w0, r0, f0, d0;
    for (int i = 0; i < 512; i++) wbuf[i] = 8'h00;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 in reset",
        int'({cs_n, sclk, busy, done}), 8);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1 && sclk == 1'b0 && busy == 1'b0 && done == 1'b0, "R1 after reset",
        int'({cs_n, sclk, busy, done}), 8);

    // R8: identifier read, R3: no write enable
    w0 = wren_frames;
    do_req(3'd5, 0, 0, e);
    chk(rcnt == 1 && rbuf[0] == ID_BYTE, "R8 id byte", int'(rbuf[0]), int'(ID_BYTE));
    chk(hdr[0] == 8'hAB && hdr[1] == 8'h00 && hdr[2] == 8'h00 && hdr[3] == 8'h00,
        "R8 id frame", int'({hdr[0], hdr[1], hdr[2], hdr[3]}), 32'hAB000000);
    chk(wren_frames == w0, "R3 no wren before id", wren_frames - w0, 0);

    // R5/R3/R6: page program wrapping in page 1
    busy_n = 3;
    for (int i = 0; i < 12; i++) wbuf[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 12; i++)
      exp_mem[256 + ((248 + i) % 256)] = exp_mem[256 + ((248 + i) % 256)] & wbuf[i];
    w0 = wren_frames; r0 = rdsr_frames;
    do_req(3'd1, 24'h0001F8, 12, e);
    chk(!e && widx == 9'd12, "R5 bytes taken", int'(widx), 12);
    chk(wren_frames == w0 + 1, "R3 wren before program", wren_frames - w0, 1);
    chk(rdsr_frames == r0 + 4, "R6 polls until clear", rdsr_frames - r0, 4);
    chk(hdr[0] == 8'h02 && hdr[1] == 8'h00 && hdr[2] == 8'h01 && hdr[3] == 8'hF8,
        "R4 address order", int'({hdr[0], hdr[1], hdr[2], hdr[3]}), 32'h020001F8);

    // R5: full page at 0x200, no busy
    busy_n = 0;
    for (int i = 0; i < 256; i++) wbuf[i] = 8'((i * 13 + 1) ^ 8'h5A);
    for (int i = 0; i < 256; i++) exp_mem[512 + i] = exp_mem[512 + i] & wbuf[i];
    r0 = rdsr_frames;
    do_req(3'd1, 24'h000200, 256, e);
    chk(!e && rdsr_frames == r0 + 1, "R6 single poll when idle", rdsr_frames - r0, 1);

    // R4/R5: read sweep
    rd_check(256, 256, "R5 page 1 image");
    rd_check(512, 256, "R5 page 2 image");
    foreach (wbuf[k]) if (k < 1) ; // no-op keeps loop syntax local
    for (int s = 0; s < 4; s++)
      for (int n = 1; n <= 5; n++)
        rd_check((s * 253 + 250) % 1024, n, "R4 read sweep");

    // R3/R4: sector erase in sector 0
    w0 = wren_frames;
    busy_n = 2;
    do_req(3'd2, 24'h0001AB, 0, e);
    for (int i = 0; i < 512; i++) exp_mem[i] = 8'hFF;
    chk(!e && wren_frames == w0 + 1, "R3 wren before sector erase", wren_frames - w0, 1);
    chk(hdr[0] == 8'hD8 && hdr[3] == 8'hAB, "R4 erase header", int'({hdr[0], hdr[3]}), 16'hD8AB);
    rd_check(496, 32, "R4 erase boundary");

    // R3: write status
    w0 = wren_frames;
    wbuf[0] = 8'h1C;
    do_req(3'd4, 0, 0, e);
    chk(!e && sr_val == 8'h1C, "R3 status byte", int'(sr_val), 16'h1C);
    chk(wren_frames == w0 + 1, "R3 wren before status write", wren_frames - w0, 1);

    // R3: bulk erase
    w0 = wren_frames;
    do_req(3'd3, 0, 0, e);
    for (int i = 0; i < 1024; i++) exp_mem[i] = 8'hFF;
    chk(!e && hdr[0] == 8'hC7 && wren_frames == w0 + 1, "R3 bulk erase",
        int'(hdr[0]), 16'hC7);
    rd_check(600, 8, "R3 bulk erase readback");

    // R7: poll budget exhausted
    busy_n = 10;
    r0 = rdsr_frames;
    wbuf[0] = 8'h00;
    do_req(3'd1, 0, 1, e);
    chk(e == 1'b1, "R7 err flag", int'(e), 1);
    chk(rdsr_frames == r0 + POLL_LIMIT, "R7 poll count", rdsr_frames - r0, POLL_LIMIT);
    wip_left = 0;
    busy_n = 0;
    chk(violations == 0, "R3 no modify without wren", violations, 0);

    // R10: requests while busy are ignored
    f0 = frames; d0 = done_cnt;
    @(negedge clk);
    rcnt = 0;
    req_valid = 1'b1; req_cmd = 3'd0; req_addr = 24'd0; req_len = LEN_W'(4);
    @(negedge clk);
    req_cmd = 3'd3;
    chk(busy == 1'b1, "R10 busy after accept", int'(busy), 1);
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(done_cnt == d0 + 1 && frames == f0 + 1, "R10 one frame one done",
        frames - f0, 1);
    chk(hdr[0] == 8'h03 && busy == 1'b0, "R10 read kept", int'(hdr[0]), 3);

    // R2/R9: serial timing seen over the whole run
    chk(min_hi == CLK_DIV && max_hi == CLK_DIV, "R2 sclk high phase", max_hi, CLK_DIV);
    chk(min_lo == CLK_DIV, "R2 sclk low phase", min_lo, CLK_DIV);
    chk(min_gap >= 2 * CLK_DIV, "R9 cs high gap", min_gap, 2 * CLK_DIV);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule